// File: doc/BRIEF.md
# Hashed Page Table Group Search

This block finds the page table entry that translates an effective address inside one segment. It works through a hashed page table in memory. The request supplies the segment descriptor, the segment offset bits of the effective address and three configuration values: the table base, the group mask and the segment page shift. A clamp input forces the page size to 4 KB. From these the engine forms a group hash and a compare word. It then reads the eight entries of the primary group one at a time, in ascending order, over a single-outstanding memory read port. If no entry qualifies, it reads the eight entries of the secondary group, which is addressed by the bitwise complement of the hash.

Each entry is 128 bits. Word 0 is bits 63:0 and word 1 is bits 127:64. Word 0 holds the tag, laid out as follows:

| Bits | Field |
|------|-------|
| 63:62 | segment size code (00 = 256 MB, 01 = 1 TB) |
| 61:59 | ignored |
| 58:7 | abbreviated virtual page number (AVPN, 52 bits) |
| 6:3 | ignored |
| 2 | large-page flag |
| 1 | secondary-hash flag |
| 0 | valid |

Word 1 bits 15:12 carry the large-page size code. The search ends with a one-cycle `done` pulse. At that pulse `found`, the entry index and both words of the first qualifying entry are presented, and they hold until the next result.

Top module: `hpt_group_search`

## Requirements
- R1: For a 256 MB segment (`seg_1t`=0) the hash is `seg_vsid` XOR (`ea_low[27:0]` >> ps), where ps is the effective page shift. The primary group is hash AND `tbl_mask`. Entry index = group*8 + slot. Read address = `tbl_base` + index*16. Slots are read 0 to 7 in order.
- R2: For a 1 TB segment (`seg_1t`=1) let V = `seg_vsid[39:12]`. The hash is V XOR (V << 25) XOR (`ea_low[39:0]` >> ps).
- R3: An entry qualifies only if all of these hold: word 0 bit 0 is 1; bits 63:62 equal the segment size code; bits 1 equal the current pass (0 primary, 1 secondary); bits 58:7 equal the AVPN. For 256 MB the AVPN is {`seg_vsid`, O[27:16]}. For 1 TB it is {`seg_vsid[39:12]`, O[39:16]}. Here O is the segment offset with the bits below ps cleared.
- R4: When no primary entry qualifies, the eight entries of group (NOT hash) AND `tbl_mask` are read in the same way, with the secondary flag required to be 1.
- R5: The first qualifying entry in read order ends the search. `done` pulses for one cycle with `found`=1, `hit_index`, `hit_w0` and `hit_w1`. These results hold until the next `done`.
- R6: A tag-matching entry is usable only in these cases: its large flag is 0 and ps is 12; or its large flag is 1, ps is 16 and word 1 bits 15:12 are 4'h1; or its large flag is 1, ps is 24 and those bits are 4'h8. Any other tag-matching entry is skipped and the search continues.
- R7: When `clamp_4k` is 1, ps is 12 for the hash, the AVPN and the size check, whatever `page_shift` says.
- R8: If neither group yields an entry, `done` pulses with `found`=0 after exactly 16 reads.
- R9: `start` is ignored while a search is running. The result reflects the inputs captured at the accepted start.
- R10: At most one read is outstanding: `rd_req` lasts one cycle and the next request waits for `rd_valid`. `done` is a single-cycle pulse and never coincides with `rd_req`.
- R11: After reset `done`, `found` and `rd_req` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| start | input | 1 | begin a search (accepted when idle) |
| seg_vsid | input | 40 | segment virtual segment identifier |
| seg_1t | input | 1 | 1 = 1 TB segment, 0 = 256 MB segment |
| ea_low | input | 40 | segment offset bits of the effective address |
| tbl_base | input | AW (48) | table base byte address, 16-byte aligned |
| tbl_mask | input | GW (20) | group index mask |
| page_shift | input | 5 | segment page shift (12, 16 or 24) |
| clamp_4k | input | 1 | force 4 KB page size |
| rd_req | output | 1 | read request, one cycle |
| rd_addr | output | AW (48) | byte address of the entry to read |
| rd_valid | input | 1 | read data valid |
| rd_data | input | 128 | entry: word 1 in bits 127:64, word 0 in bits 63:0 |
| done | output | 1 | search finished, one-cycle pulse |
| found | output | 1 | a qualifying entry was found |
| hit_index | output | GW+3 (23) | index of the found entry |
| hit_w0 | output | 64 | word 0 of the found entry |
| hit_w1 | output | 64 | word 1 of the found entry |

## Verification
Groups are seeded with decoys placed ahead of the real entry. Some have the wrong AVPN, the wrong pass flag, the wrong segment size, or a large-page encoding that does not fit. A hit behind them shows that each field of the compare takes part, separately. One run holds a primary entry that carries the secondary flag, with a hit in the secondary group; it separates the two passes and the complemented hash. Paired 256 MB and 1 TB runs, and a clamp run with a 16 MB segment page shift, each change the read address sequence. A bench model that predicts every address therefore distinguishes the hash forms. A fully empty search and a search poked with new start pulses while busy cover the miss count and the ignored start.

// File: rtl/hpt_group_search.sv
module hpt_group_search #(
  parameter int AW = 48,
  parameter int GW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [39:0]   seg_vsid,
  input  logic          seg_1t,
  input  logic [39:0]   ea_low,
  input  logic [AW-1:0] tbl_base,
  input  logic [GW-1:0] tbl_mask,
  input  logic [4:0]    page_shift,
  input  logic          clamp_4k,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_valid,
  input  logic [127:0]  rd_data,
  output logic          done,
  output logic          found,
  output logic [GW+2:0] hit_index,
  output logic [63:0]   hit_w0,
  output logic [63:0]   hit_w1
);
  localparam int IW = GW + 3;
  localparam int VW = 40;
  localparam int OW = 40;
  localparam int PW = VW + 12;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT} st_t;

  st_t           st;
  logic [VW-1:0] q_vsid;
  logic          q_1t;
  logic [OW-1:0] q_ea;
  logic [AW-1:0] q_base;
  logic [GW-1:0] q_mask;
  logic [4:0]    q_ps;
  logic          pass;
  logic [2:0]    slot;

  logic [VW-1:0] v_eff, v_sh;
  logic [OW-1:0] off, pgno, off_hi;
  logic [GW-1:0] hash, grp;
  logic [IW-1:0] idx;
  logic [PW-1:0] avpn;
  logic [1:0]    ssize;
  logic [63:0]   w0, w1;
  logic          tag_ok, size_ok, hit;

  assign v_eff  = q_1t ? {12'b0, q_vsid[VW-1:12]} : q_vsid;
  assign v_sh   = q_1t ? (v_eff << 25) : '0;
  assign off    = q_1t ? q_ea : {12'b0, q_ea[27:0]};
  assign pgno   = off >> q_ps;
  assign off_hi = OW'((pgno << q_ps) >> 16);
  assign hash   = GW'(v_eff ^ v_sh ^ pgno);
  assign grp    = (pass ? ~hash : hash) & q_mask;
  assign idx    = {grp, slot};
  assign avpn   = q_1t ? {q_vsid[VW-1:12], off_hi[23:0]} : {q_vsid, off_hi[11:0]};
  assign ssize  = q_1t ? 2'b01 : 2'b00;

  assign rd_req  = (st == S_REQ);
  assign rd_addr = q_base + (AW'(idx) << 4);

  assign w0 = rd_data[63:0];
  assign w1 = rd_data[127:64];

  assign tag_ok = w0[0] && (w0[1] == pass) && (w0[63:62] == ssize)
                  && (w0[7 +: PW] == avpn);

  always_comb begin
    if (!w0[2])
      size_ok = (q_ps == 5'd12);
    else
      size_ok = ((q_ps == 5'd16) && (w1[15:12] == 4'h1)) ||
                ((q_ps == 5'd24) && (w1[15:12] == 4'h8));
  end

  assign hit = tag_ok && size_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      q_vsid    <= '0;
      q_1t      <= 1'b0;
      q_ea      <= '0;
      q_base    <= '0;
      q_mask    <= '0;
      q_ps      <= 5'd12;
      pass      <= 1'b0;
      slot      <= '0;
      done      <= 1'b0;
      found     <= 1'b0;
      hit_index <= '0;
      hit_w0    <= '0;
      hit_w1    <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: begin
          if (start) begin
            q_vsid <= seg_vsid;
            q_1t   <= seg_1t;
            q_ea   <= ea_low;
            q_base <= tbl_base;
            q_mask <= tbl_mask;
            q_ps   <= clamp_4k ? 5'd12 : page_shift;
            pass   <= 1'b0;
            slot   <= '0;
            st     <= S_REQ;
          end
        end
        S_REQ: st <= S_WAIT;
        S_WAIT: begin
          if (rd_valid) begin
            if (hit) begin
              done      <= 1'b1;
              found     <= 1'b1;
              hit_index <= idx;
              hit_w0    <= w0;
              hit_w1    <= w1;
              st        <= S_IDLE;
            end else if (slot == 3'd7) begin
              if (!pass) begin
                pass <= 1'b1;
                slot <= '0;
                st   <= S_REQ;
              end else begin
                done  <= 1'b1;
                found <= 1'b0;
                st    <= S_IDLE;
              end
            end else begin
              slot <= slot + 3'd1;
              st   <= S_REQ;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hpt_group_search_chk.sv
module hpt_group_search_chk #(
  parameter int GW = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_req,
  input logic          done,
  input logic          found,
  input logic [63:0]   hit_w0
);
  logic [4:0] n_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      n_rd <= '0;
    else if (done)   n_rd <= '0;
    else if (rd_req) n_rd <= n_rd + 5'd1;
  end

  p_one_outstanding_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req);

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_no_req_at_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !rd_req);

  p_found_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && found) |-> hit_w0[0]);

  p_found_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> (done || $stable(found)));

  p_read_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> (n_rd < 5'd16));

  p_miss_reads_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !found) |-> (n_rd == 5'd16));
endmodule

bind hpt_group_search hpt_group_search_chk #(.GW(GW)) chk_i (
  .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .done(done),
  .found(found), .hit_w0(hit_w0)
);

// File: tb/hpt_group_search_tb.sv
module hpt_group_search_tb_top;
  localparam int AW = 48;
  localparam int GW = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [39:0]   seg_vsid = '0;
  logic          seg_1t = 1'b0;
  logic [39:0]   ea_low = '0;
  logic [AW-1:0] tbl_base = '0;
  logic [GW-1:0] tbl_mask = '0;
  logic [4:0]    page_shift = 5'd12;
  logic          clamp_4k = 1'b0;
  logic          rd_req;
  logic [AW-1:0] rd_addr;
  logic          rd_valid = 1'b0;
  logic [127:0]  rd_data = '0;
  logic          done, found;
  logic [GW+2:0] hit_index;
  logic [63:0]   hit_w0, hit_w1;

  always #4 clk = ~clk;

  hpt_group_search #(.AW(AW), .GW(GW)) dut_i (.*);

  bit [127:0] mem [longint unsigned];
  bit [63:0]  exp_addr [$];
  bit         exp_found;
  bit [63:0]  exp_idx, exp_w0, exp_w1;
  bit         running = 0, got_done = 0;
  int         lat = 1, rv_cnt = 0, run_cyc = 0;
  bit [127:0] pend;
  int         n_chk = 0, n_fail = 0;
  string      cur_req = "R11";

  task automatic chk(bit ok, string req, string what, bit [127:0] act, bit [127:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  function automatic bit [63:0] eff_ps();
    return clamp_4k ? 64'd12 : 64'(page_shift);
  endfunction

  function automatic bit [63:0] ref_hash();
    bit [63:0] v, off, ps;
    ps = eff_ps();
    if (seg_1t) begin
      v = 64'(seg_vsid) >> 12; off = 64'(ea_low);
      return v ^ (v << 25) ^ (off >> ps);
    end
    v = 64'(seg_vsid); off = 64'(ea_low) & 64'hFFF_FFFF;
    return v ^ (off >> ps);
  endfunction

  function automatic bit [51:0] ref_avpn();
    bit [63:0] off, ps, offm;
    ps = eff_ps();
    off = seg_1t ? 64'(ea_low) : (64'(ea_low) & 64'hFFF_FFFF);
    offm = (off >> ps) << ps;
    if (seg_1t) return 52'(((64'(seg_vsid) >> 12) << 24) | (offm >> 16));
    return 52'((64'(seg_vsid) << 12) | (offm >> 16));
  endfunction

  function automatic bit [63:0] ent(int ps2, int s);
    bit [63:0] h, g;
    h = ref_hash();
    g = (ps2 != 0 ? ~h : h) & 64'(tbl_mask);
    return g * 8 + 64'(s);
  endfunction

  function automatic bit [63:0] mk_w0(bit [1:0] ss, bit [51:0] av, bit l, bit hh);
    return {ss, 3'b0, av, 4'b0, l, hh, 1'b1};
  endfunction

  function automatic bit [127:0] rdmem(bit [63:0] i);
    if (mem.exists(i)) return mem[i];
    return '0;
  endfunction

  task automatic compute_ref();
    bit [51:0] av;
    bit [63:0] ps, i, w0, w1;
    bit [127:0] e;
    bit tok, sok;
    av = ref_avpn();
    ps = eff_ps();
    exp_addr.delete();
    exp_found = 0; exp_idx = 0; exp_w0 = 0; exp_w1 = 0;
    for (int p = 0; p < 2; p++) begin
      for (int s = 0; s < 8; s++) begin
        i = ent(p, s);
        exp_addr.push_back(64'(tbl_base) + i * 16);
        e = rdmem(i); w0 = e[63:0]; w1 = e[127:64];
        tok = w0[0] && (w0[1] == p[0]) && (w0[63:62] == {1'b0, seg_1t}) && (w0[58:7] == av);
        if (!w0[2]) sok = (ps == 12);
        else sok = (ps == 16 && w1[15:12] == 4'h1) || (ps == 24 && w1[15:12] == 4'h8);
        if (tok && sok) begin
          exp_found = 1; exp_idx = i; exp_w0 = w0; exp_w1 = w1;
          return;
        end
      end
    end
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (rv_cnt > 0) begin
        rv_cnt--;
        if (rv_cnt == 0) begin rd_valid = 1; rd_data = pend; end
        else rd_valid = 0;
      end else rd_valid = 0;
      if (rd_req) begin
        if (!running || exp_addr.size() == 0)
          chk(0, cur_req, "unexpected rd_req", 128'(rd_addr), 0);
        else
          chk(64'(rd_addr) == exp_addr[0], cur_req, "rd_addr", 128'(rd_addr), 128'(exp_addr[0]));
        if (exp_addr.size() > 0) void'(exp_addr.pop_front());
        chk(rv_cnt == 0, "R10", "overlapping request", 128'(rv_cnt), 0);
        pend = rdmem((64'(rd_addr) - 64'(tbl_base)) >> 4);
        rv_cnt = lat;
      end
      if (done) begin
        if (!running) chk(0, cur_req, "unexpected done", 1, 0);
        else begin
          chk(exp_addr.size() == 0, exp_found ? cur_req : "R8", "reads left at done", 128'(exp_addr.size()), 0);
          chk(found == exp_found, cur_req, "found", 128'(found), 128'(exp_found));
          if (exp_found) begin
            chk(64'(hit_index) == exp_idx, "R5", "hit_index", 128'(hit_index), 128'(exp_idx));
            chk(hit_w0 == exp_w0, "R5", "hit_w0", 128'(hit_w0), 128'(exp_w0));
            chk(hit_w1 == exp_w1, "R5", "hit_w1", 128'(hit_w1), 128'(exp_w1));
          end
        end
        got_done = 1;
      end
      if (running) begin
        run_cyc++;
        if (run_cyc > 3000) begin
          chk(0, cur_req, "watchdog expired", 0, 1);
          got_done = 1;
        end
      end
    end
  end

  task automatic run(string req, int l, bit poke);
    cur_req = req; lat = l;
    compute_ref();
    run_cyc = 0; got_done = 0; running = 1;
    start = 1;
    @(negedge clk);
    if (poke) begin
      // R9: new start pulses with other inputs while busy
      for (int k = 0; k < 3; k++) begin
        ea_low = ~ea_low; seg_vsid = ~seg_vsid;
        @(negedge clk);
      end
    end
    start = 0;
    wait (got_done);
    running = 0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic setup(bit [39:0] v, bit t, bit [39:0] ea, bit [4:0] ps, bit cl);
    mem.delete();
    seg_vsid = v; seg_1t = t; ea_low = ea; page_shift = ps; clamp_4k = cl;
    tbl_base = 48'h0000_1000_0000; tbl_mask = 20'h003FF;
  endtask

  initial begin
    bit [51:0] av;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(done == 0, "R11", "done after reset", 128'(done), 0);
    chk(found == 0, "R11", "found after reset", 128'(found), 0);
    chk(rd_req == 0, "R11", "rd_req after reset", 128'(rd_req), 0);

    // R1 R5: 256 MB, hit at slot 0
    setup(40'h12_3456_789A, 0, 40'h00_0ABC_D123, 12, 0);
    av = ref_avpn();
    mem[ent(0, 0)] = {64'h0000_0000_00AB_C000, mk_w0(2'b00, av, 0, 0)};
    run("R1", 1, 0);

    // R3: decoys ahead of the hit at slot 5
    setup(40'h0F_0E0D_0C0B, 0, 40'h00_0765_4321, 12, 0);
    av = ref_avpn();
    mem[ent(0, 1)] = {64'h0, mk_w0(2'b00, av ^ 52'h1, 0, 0)};
    mem[ent(0, 2)] = {64'h0, mk_w0(2'b00, av, 0, 1)};
    mem[ent(0, 3)] = {64'h0, mk_w0(2'b01, av, 0, 0)};
    mem[ent(0, 4)] = {64'h0, mk_w0(2'b00, av, 0, 0) & ~64'h1};
    mem[ent(0, 5)] = {64'h1111_2222_3333_4444, mk_w0(2'b00, av, 0, 0)};
    run("R3", 2, 0);

    // R5: two matches, first in order wins
    setup(40'h00_0000_0042, 0, 40'h00_0123_4567, 12, 0);
    av = ref_avpn();
    mem[ent(0, 4)] = {64'hAAAA, mk_w0(2'b00, av, 0, 0)};
    mem[ent(0, 6)] = {64'hBBBB, mk_w0(2'b00, av, 0, 0)};
    run("R5", 1, 0);

    // R4: secondary pass
    setup(40'h55_AA55_AA55, 0, 40'h00_0FED_C000, 12, 0);
    av = ref_avpn();
    mem[ent(0, 3)] = {64'h0, mk_w0(2'b00, av, 0, 1)};
    mem[ent(1, 2)] = {64'h0, mk_w0(2'b00, av, 0, 0)};
    mem[ent(1, 7)] = {64'h7777, mk_w0(2'b00, av, 0, 1)};
    run("R4", 1, 0);

    // R2: 1 TB segment, segment-size decoy
    setup(40'h9A_BCDE_F000, 1, 40'hC3_2109_8765, 12, 0);
    av = ref_avpn();
    mem[ent(0, 0)] = {64'h0, mk_w0(2'b00, av, 0, 0)};
    mem[ent(0, 1)] = {64'h5150, mk_w0(2'b01, av, 0, 0)};
    run("R2", 1, 0);

    // R6: 64 KB pages, size-encoding decoys
    setup(40'h31_4159_2653, 0, 40'h00_0AB1_2345, 16, 0);
    av = ref_avpn();
    mem[ent(0, 0)] = {64'h0, mk_w0(2'b00, av, 0, 0)};
    mem[ent(0, 1)] = {64'h8000, mk_w0(2'b00, av, 1, 0)};
    mem[ent(0, 2)] = {64'h1000, mk_w0(2'b00, av, 1, 0)};
    run("R6", 1, 0);

    // R6 R2: 16 MB pages in a 1 TB segment
    setup(40'h27_1828_1000, 1, 40'h45_6789_ABCD, 24, 0);
    av = ref_avpn();
    mem[ent(0, 2)] = {64'h1000, mk_w0(2'b01, av, 1, 0)};
    mem[ent(0, 6)] = {64'h0300_8000, mk_w0(2'b01, av, 1, 0)};
    run("R6", 3, 0);

    // R7: clamp forces 4 KB
    setup(40'h0A_0B0C_0D0E, 0, 40'h00_0345_6789, 24, 1);
    av = ref_avpn();
    mem[ent(0, 0)] = {64'h8000, mk_w0(2'b00, av, 1, 0)};
    mem[ent(0, 1)] = {64'h0CAF_E000, mk_w0(2'b00, av, 0, 0)};
    run("R7", 1, 0);

    // R8: complete miss with wrong-pass entries everywhere
    setup(40'h66_6666_6666, 0, 40'h00_0111_1000, 12, 0);
    av = ref_avpn();
    for (int s = 0; s < 8; s++) begin
      mem[ent(0, s)] = {64'h0, mk_w0(2'b00, av, 0, 1)};
      mem[ent(1, s)] = {64'h0, mk_w0(2'b00, av, 0, 0)};
    end
    run("R8", 2, 0);

    // R9: start ignored while busy
    setup(40'h13_5792_4680, 0, 40'h00_0246_8ACE, 12, 0);
    av = ref_avpn();
    mem[ent(0, 5)] = {64'h9999, mk_w0(2'b00, av, 0, 0)};
    run("R9", 1, 1);

    // R10: long latency, secondary hit at the last slot
    setup(40'h70_F0E1_D2C3, 0, 40'h00_0999_9000, 12, 0);
    av = ref_avpn();
    mem[ent(1, 7)] = {64'h4242, mk_w0(2'b00, av, 0, 1)};
    run("R10", 3, 0);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL %s global watchdog actual=%0d expected=%0d", cur_req, 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule